// File: doc/BRIEF.md
# Event Channel Controller with Channel Groups

This block keeps the on/off state of a set of event-routing channels and lets software change that state through a single-cycle register port. Software can turn channels on or off by mask, and it can also gather channels into groups. Each group stores a channel mask and offers two tasks: one that switches on every channel in the mask, and one that switches them all off.

A task fires when software writes to it. It can also fire through a subscription, which ties the task to one channel. A one-cycle event pulse on that channel then fires the task, but only while the channel itself is switched on. While either task of a group is subscribed, the group's mask is frozen. This means a group cannot be reshaped while events are able to act on it. The current channel states are driven out on a vector for the routing fabric.

Top module: `evt_chan_ctrl`

Register layout (byte addresses, 32-bit data): group task registers start at 0x000, with the enable task at 0x000+8g and the disable task at 0x004+8g. Each task's subscription register sits at the task address plus 0x080. The channel state reads at 0x100. The set mask is at 0x104 and the clear mask is at 0x108. The mask of group g is at 0x140+4g.

## Requirements
- R1: After a synchronous active-low reset, every channel is off, every group mask reads 0 and every subscription register reads 0.
- R2: Writing a mask to 0x104 switches on the channels whose bits are 1. Channels whose bits are 0 keep their state.
- R3: Writing a mask to 0x108 switches off the channels whose bits are 1. Writing all ones switches off every channel.
- R4: Reads at 0x100, 0x104 and 0x108 return the channel state vector. Writes to 0x100 have no effect.
- R5: A write to the mask register of group g (0x140+4g) replaces the whole mask, and the mask reads back. Writing 0 empties the group.
- R6: Writing a value with bit 0 set to the enable task (0x000+8g) switches on every channel in that group's mask. The disable task (0x004+8g) switches them off. Writes with bit 0 clear do nothing, and task addresses read as 0.
- R7: All set and clear requests of one cycle are merged, with clears applied after sets. If a group's enable and disable tasks fire together, disable wins. A clear register write also beats a set from any source.
- R8: A subscription register (task address + 0x080) keeps only bit 31, the enable flag, and bits 4:0, the channel number. All other bits read as 0. Writing 0 removes the subscription, and events on the channel then no longer fire the task.
- R9: A subscribed task fires on a one-cycle event pulse of its channel only while that channel is on. Pulses on channels that are off change nothing.
- R10: While the subscription of either task of a group is enabled, writes to that group's mask are ignored. Other groups' masks stay writable.
- R11: Every write or event takes effect on the channel state output at the next clock edge. There is one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 9 | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| ev_pulse_i | input | NUM_CH | One-cycle event pulses, one per channel |
| ch_en_o | output | NUM_CH | Current channel on/off state |

## Verification
The assertions assume that each bus write lasts exactly one cycle. They also assume that event pulses are the only source of channel change besides writes, so a cycle with no write and no pulse on an enabled channel must leave the state alone. The stimulus drives writes for one cycle at a time, away from the clock edge. Pulses are kept to single cycles, and each pulse is either alone or, in the priority scenario, deliberately combined with one write. Subscriptions are always removed before masks are rewritten, so the frozen-mask rule is only exercised where it is meant to be.

// File: rtl/evt_chan_pkg.sv
// Shared constants for the event channel controller: address map and
// subscription field positions. Assumes word-aligned 32-bit accesses.
package evt_chan_pkg;
    localparam int          BUS_AW     = 9;
    localparam int          BUS_DW     = 32;
    localparam logic [8:0]  TASK_BASE  = 9'h000;
    localparam logic [8:0]  SUB_OFFSET = 9'h080;
    localparam logic [8:0]  STAT_ADDR  = 9'h100;
    localparam logic [8:0]  SET_ADDR   = 9'h104;
    localparam logic [8:0]  CLR_ADDR   = 9'h108;
    localparam logic [8:0]  MASK_BASE  = 9'h140;
    localparam int          TASK_STEP  = 8;
    localparam int          MASK_STEP  = 4;
    localparam int          SUB_ON_BIT = 31;
endpackage

// File: rtl/ecg_sub_unit.sv
// Subscription register for one group task. Holds an enable flag and a
// channel number, and raises fire_o when the chosen channel pulses while
// that channel is on. Assumes NUM_CH >= 2.
module ecg_sub_unit #(
    parameter int NUM_CH = 32,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              on_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [NUM_CH-1:0] ev_pulse_i,
    input  logic [NUM_CH-1:0] ch_en_i,
    output logic              on_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              fire_o
);
    localparam int PAD = 1 << CH_W;

    logic            on_q;
    logic [CH_W-1:0] ch_q;
    logic [PAD-1:0]  ev_ext;
    logic [PAD-1:0]  en_ext;

    // Hold the subscription fields, replaced as a whole on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0;
            ch_q <= '0;
        end else if (wr_i) begin
            on_q <= on_i;
            ch_q <= ch_i;
        end
    end

    // Zero-pad so channel numbers beyond NUM_CH select an idle line.
    always_comb begin
        ev_ext = PAD'(ev_pulse_i);
        en_ext = PAD'(ch_en_i);
    end

    // Fire only for a pulse on a subscribed, currently enabled channel.
    assign fire_o = on_q & ev_ext[ch_q] & en_ext[ch_q];
    assign on_o   = on_q;
    assign ch_o   = ch_q;
endmodule

// File: rtl/ecg_group.sv
// One channel group: mask register, enable and disable tasks with their
// subscriptions, and the set/clear vectors the tasks request this cycle.
// The mask is frozen while either subscription is enabled.
module ecg_group #(
    parameter int NUM_CH = 32,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr_i,
    input  logic              task_on_wr_i,
    input  logic              task_off_wr_i,
    input  logic              sub_on_wr_i,
    input  logic              sub_off_wr_i,
    input  logic [NUM_CH-1:0] mask_data_i,
    input  logic              task_bit_i,
    input  logic              sub_flag_i,
    input  logic [CH_W-1:0]   sub_ch_i,
    input  logic [NUM_CH-1:0] ev_pulse_i,
    input  logic [NUM_CH-1:0] ch_en_i,
    output logic [NUM_CH-1:0] mask_o,
    output logic              lock_o,
    output logic [NUM_CH-1:0] set_vec_o,
    output logic [NUM_CH-1:0] clr_vec_o,
    output logic [31:0]       sub_on_rd_o,
    output logic [31:0]       sub_off_rd_o
);
    logic [NUM_CH-1:0] mask_q;
    logic              a_on, b_on, a_fire, b_fire;
    logic [CH_W-1:0]   a_ch, b_ch;
    logic              fire_on, fire_off;

    ecg_sub_unit #(.NUM_CH(NUM_CH), .CH_W(CH_W)) sub_on_i (
        .clk(clk), .rst_n(rst_n), .wr_i(sub_on_wr_i), .on_i(sub_flag_i),
        .ch_i(sub_ch_i), .ev_pulse_i(ev_pulse_i), .ch_en_i(ch_en_i),
        .on_o(a_on), .ch_o(a_ch), .fire_o(a_fire)
    );

    ecg_sub_unit #(.NUM_CH(NUM_CH), .CH_W(CH_W)) sub_off_i (
        .clk(clk), .rst_n(rst_n), .wr_i(sub_off_wr_i), .on_i(sub_flag_i),
        .ch_i(sub_ch_i), .ev_pulse_i(ev_pulse_i), .ch_en_i(ch_en_i),
        .on_o(b_on), .ch_o(b_ch), .fire_o(b_fire)
    );

    assign lock_o = a_on | b_on;

    // Replace the mask on a write unless a subscription freezes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr_i && !lock_o) begin
            mask_q <= mask_data_i;
        end
    end

    // Combine software and event triggers into this cycle's requests.
    always_comb begin
        fire_on   = (task_on_wr_i & task_bit_i) | a_fire;
        fire_off  = (task_off_wr_i & task_bit_i) | b_fire;
        set_vec_o = fire_on  ? mask_q : '0;
        clr_vec_o = fire_off ? mask_q : '0;
    end

    // Present subscription fields in their read-back positions.
    always_comb begin
        sub_on_rd_o              = '0;
        sub_on_rd_o[31]          = a_on;
        sub_on_rd_o[CH_W-1:0]    = a_ch;
        sub_off_rd_o             = '0;
        sub_off_rd_o[31]         = b_on;
        sub_off_rd_o[CH_W-1:0]   = b_ch;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/ecg_chan_state.sv
// Channel on/off register. Applies the merged set requests first and the
// merged clear requests after them, so a clear always wins.
module ecg_chan_state #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] en_o
);
    logic [NUM_CH-1:0] en_q;

    // Update state: sets, then clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | set_i) & ~clr_i;
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/evt_chan_ctrl.sv
// Top of the event channel controller. Decodes the single-cycle register
// port, builds NUM_GRP groups (2, 4 or 6 expected), merges all set/clear
// requests and returns read data combinationally. NUM_CH is 2..32.
module evt_chan_ctrl
    import evt_chan_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    input  logic [NUM_CH-1:0] ev_pulse_i,
    output logic [NUM_CH-1:0] ch_en_o
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [NUM_GRP-1:0][NUM_CH-1:0] grp_mask;
    logic [NUM_GRP-1:0][NUM_CH-1:0] grp_set;
    logic [NUM_GRP-1:0][NUM_CH-1:0] grp_clr;
    logic [NUM_GRP-1:0]             grp_lock;
    logic [NUM_GRP-1:0][31:0]       sub_on_rd;
    logic [NUM_GRP-1:0][31:0]       sub_off_rd;
    logic [NUM_CH-1:0]              set_all, clr_all;
    logic [NUM_CH-1:0]              ch_en;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [BUS_AW-1:0] A_TON  = TASK_BASE + BUS_AW'(TASK_STEP * g);
        localparam logic [BUS_AW-1:0] A_TOFF = A_TON + BUS_AW'(4);
        localparam logic [BUS_AW-1:0] A_MASK = MASK_BASE + BUS_AW'(MASK_STEP * g);

        ecg_group #(.NUM_CH(NUM_CH), .CH_W(CH_W)) grp_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .mask_wr_i    (bus_we_i && bus_addr_i == A_MASK),
            .task_on_wr_i (bus_we_i && bus_addr_i == A_TON),
            .task_off_wr_i(bus_we_i && bus_addr_i == A_TOFF),
            .sub_on_wr_i  (bus_we_i && bus_addr_i == (A_TON + SUB_OFFSET)),
            .sub_off_wr_i (bus_we_i && bus_addr_i == (A_TOFF + SUB_OFFSET)),
            .mask_data_i  (bus_wdata_i[NUM_CH-1:0]),
            .task_bit_i   (bus_wdata_i[0]),
            .sub_flag_i   (bus_wdata_i[SUB_ON_BIT]),
            .sub_ch_i     (bus_wdata_i[CH_W-1:0]),
            .ev_pulse_i   (ev_pulse_i),
            .ch_en_i      (ch_en),
            .mask_o       (grp_mask[g]),
            .lock_o       (grp_lock[g]),
            .set_vec_o    (grp_set[g]),
            .clr_vec_o    (grp_clr[g]),
            .sub_on_rd_o  (sub_on_rd[g]),
            .sub_off_rd_o (sub_off_rd[g])
        );
    end

    // Merge register-port and group-task requests for this cycle.
    always_comb begin
        set_all = (bus_we_i && bus_addr_i == SET_ADDR) ? bus_wdata_i[NUM_CH-1:0] : '0;
        clr_all = (bus_we_i && bus_addr_i == CLR_ADDR) ? bus_wdata_i[NUM_CH-1:0] : '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            set_all = set_all | grp_set[g];
            clr_all = clr_all | grp_clr[g];
        end
    end

    ecg_chan_state #(.NUM_CH(NUM_CH)) state_i (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_all),
        .clr_i(clr_all),
        .en_o (ch_en)
    );

    // Select read data; task addresses and unmapped addresses read 0.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == STAT_ADDR || bus_addr_i == SET_ADDR || bus_addr_i == CLR_ADDR) begin
            bus_rdata_o = BUS_DW'(ch_en);
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr_i == MASK_BASE + BUS_AW'(MASK_STEP * g)) begin
                bus_rdata_o = BUS_DW'(grp_mask[g]);
            end
            if (bus_addr_i == TASK_BASE + SUB_OFFSET + BUS_AW'(TASK_STEP * g)) begin
                bus_rdata_o = sub_on_rd[g];
            end
            if (bus_addr_i == TASK_BASE + SUB_OFFSET + BUS_AW'(TASK_STEP * g + 4)) begin
                bus_rdata_o = sub_off_rd[g];
            end
        end
    end

    assign ch_en_o = ch_en;
endmodule

// File: rtl/evt_chan_ctrl_chk.sv
// Property checker for evt_chan_ctrl, attached by bind. Assumes one-cycle
// bus writes and that only writes and event pulses change channel state.
module evt_chan_ctrl_chk
    import evt_chan_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [BUS_AW-1:0]              bus_addr_i,
    input logic                           bus_we_i,
    input logic [BUS_DW-1:0]              bus_wdata_i,
    input logic [BUS_DW-1:0]              bus_rdata_o,
    input logic [NUM_CH-1:0]              ev_pulse_i,
    input logic [NUM_CH-1:0]              ch_en_o,
    input logic [NUM_GRP-1:0][NUM_CH-1:0] grp_mask_i,
    input logic [NUM_GRP-1:0]             grp_lock_i
);
    // R2
    set_write_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == SET_ADDR && ev_pulse_i == '0)
        |=> ((ch_en_o & $past(bus_wdata_i[NUM_CH-1:0])) == $past(bus_wdata_i[NUM_CH-1:0])));

    // R3
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == CLR_ADDR && bus_wdata_i[NUM_CH-1:0] == '1)
        |=> (ch_en_o == '0));

    // R9
    idle_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_i && (ev_pulse_i & ch_en_o) == '0) |=> $stable(ch_en_o));

    // R6
    task_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i < SUB_OFFSET) |-> (bus_rdata_o == '0));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lock
        // R10
        mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_lock_i[g] |=> $stable(grp_mask_i[g]));
    end
endmodule

bind evt_chan_ctrl evt_chan_ctrl_chk #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr_i (bus_addr_i),
    .bus_we_i   (bus_we_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .ev_pulse_i (ev_pulse_i),
    .ch_en_o    (ch_en_o),
    .grp_mask_i (grp_mask),
    .grp_lock_i (grp_lock)
);

// File: tb/evt_chan_ctrl_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module evt_chan_ctrl_tb_top;
    localparam int NUM_CH  = 32;
    localparam int NUM_GRP = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [8:0]        bus_addr_i = '0;
    logic              bus_we_i = 1'b0;
    logic [31:0]       bus_wdata_i = '0;
    logic [31:0]       bus_rdata_o;
    logic [NUM_CH-1:0] ev_pulse_i = '0;
    logic [NUM_CH-1:0] ch_en_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    evt_chan_ctrl #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .ev_pulse_i(ev_pulse_i), .ch_en_o(ch_en_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_we_i = 1'b0;
        #1 d = bus_rdata_o;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] m);
        @(negedge clk);
        ev_pulse_i = m;
        @(negedge clk);
        ev_pulse_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 state", 32'(ch_en_o), 32'h0);
        for (int g = 0; g < NUM_GRP; g++) begin
            rd(9'h140 + 9'(4 * g), v); check("R1 mask", v, 32'h0);
            rd(9'h080 + 9'(8 * g), v); check("R1 sub on", v, 32'h0);
            rd(9'h084 + 9'(8 * g), v); check("R1 sub off", v, 32'h0);
        end
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(9'h104, 32'h0000_00F0); check("R2 set", 32'(ch_en_o), 32'h0000_00F0);
        wr(9'h104, 32'h0F00_0001); check("R2 keep", 32'(ch_en_o), 32'h0F00_00F1);
        wr(9'h108, 32'h0000_0010); check("R3 clear", 32'(ch_en_o), 32'h0F00_00E1);
        rd(9'h100, v); check("R4 read stat", v, 32'h0F00_00E1);
        rd(9'h108, v); check("R4 read clr", v, 32'h0F00_00E1);
        wr(9'h100, 32'hFFFF_FFFF); check("R4 stat write ignored", 32'(ch_en_o), 32'h0F00_00E1);
        wr(9'h108, 32'hFFFF_FFFF); check("R3 clear all", 32'(ch_en_o), 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(9'h140, 32'h0000_00A5); rd(9'h140, v); check("R5 mask", v, 32'h0000_00A5);
        wr(9'h140, 32'h0000_0300); rd(9'h140, v); check("R5 replace", v, 32'h0000_0300);
        wr(9'h140, 32'h0);         rd(9'h140, v); check("R5 empty", v, 32'h0);
        wr(9'h154, 32'hFFFF_0000); rd(9'h154, v); check("R5 last group", v, 32'hFFFF_0000);
        wr(9'h154, 32'h0);
    endtask

    task automatic t_tasks();
        logic [31:0] v;
        wr(9'h144, 32'h0000_FF00);
        wr(9'h008, 32'h0000_0000); check("R6 bit0 clear no fire", 32'(ch_en_o), 32'h0);
        wr(9'h008, 32'h0000_0001); check("R6 enable task", 32'(ch_en_o), 32'h0000_FF00);
        wr(9'h104, 32'h0000_0001);
        wr(9'h00C, 32'h0000_0001); check("R6 disable task", 32'(ch_en_o), 32'h0000_0001);
        rd(9'h008, v); check("R6 task reads zero", v, 32'h0);
        wr(9'h144, 32'h0); wr(9'h108, 32'hFFFF_FFFF);
    endtask

    task automatic t_priority();
        wr(9'h148, 32'h0000_00F0);
        wr(9'h14C, 32'h0000_003C);
        wr(9'h150, 32'hF000_0000);
        wr(9'h090, 32'h8000_0000);
        wr(9'h09C, 32'h8000_0001);
        wr(9'h0A0, 32'h8000_0000);
        wr(9'h0A4, 32'h8000_0000);
        wr(9'h104, 32'h0000_003F);
        pulse(32'h3);
        check("R7 merged, disable wins", 32'(ch_en_o), 32'h0000_00C3);
        // R7: bus set and event-driven clear in the same cycle
        @(negedge clk);
        bus_addr_i = 9'h104; bus_wdata_i = 32'h0000_003C; bus_we_i = 1'b1; ev_pulse_i = 32'h2;
        @(negedge clk);
        bus_we_i = 1'b0; ev_pulse_i = '0;
        check("R7 clear after set", 32'(ch_en_o), 32'h0000_00C3);
        wr(9'h090, 32'h0); wr(9'h09C, 32'h0); wr(9'h0A0, 32'h0); wr(9'h0A4, 32'h0);
        wr(9'h148, 32'h0); wr(9'h14C, 32'h0); wr(9'h150, 32'h0);
        wr(9'h108, 32'hFFFF_FFFF);
    endtask

    task automatic t_subscribe();
        logic [31:0] v;
        wr(9'h0A8, 32'h7FFF_FFE3); rd(9'h0A8, v); check("R8 field mask", v, 32'h0000_0003);
        wr(9'h0A8, 32'h8000_001F); rd(9'h0A8, v); check("R8 readback", v, 32'h8000_001F);
        wr(9'h0A8, 32'h0);         rd(9'h0A8, v); check("R8 remove", v, 32'h0);
        wr(9'h140, 32'h00FF_0000);
        wr(9'h080, 32'h8000_0007);
        pulse(32'h80); check("R9 disabled channel ignored", 32'(ch_en_o), 32'h0);
        wr(9'h104, 32'h0000_0080);
        @(negedge clk);
        ev_pulse_i = 32'h80;
        #1 check("R11 not before edge", 32'(ch_en_o), 32'h0000_0080);
        @(negedge clk);
        ev_pulse_i = '0;
        check("R9 R11 enabled channel fires", 32'(ch_en_o), 32'h00FF_0080);
        wr(9'h080, 32'h0);
        wr(9'h108, 32'h00FF_0000);
        pulse(32'h80); check("R8 unsubscribed no fire", 32'(ch_en_o), 32'h0000_0080);
        wr(9'h140, 32'h0); wr(9'h108, 32'hFFFF_FFFF);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(9'h144, 32'h0000_000F);
        wr(9'h08C, 32'h8000_0002);
        wr(9'h144, 32'h0000_00F0); rd(9'h144, v); check("R10 mask frozen", v, 32'h0000_000F);
        wr(9'h140, 32'h0000_0011); rd(9'h140, v); check("R10 other group free", v, 32'h0000_0011);
        wr(9'h08C, 32'h0);
        wr(9'h144, 32'h0000_00F0); rd(9'h144, v); check("R10 unfrozen", v, 32'h0000_00F0);
        wr(9'h140, 32'h0); wr(9'h144, 32'h0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_masks();
        t_tasks();
        t_priority();
        t_subscribe();
        t_lock();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule